// File: doc/BRIEF.md
# Output Source Selector with Deferred Commit

This block drives a 6-bit output port `y` from one of three sources: the live input port `port_i`, or the committed contents of one of two stored configuration words, A and B. A single 2-bit mode field, shared by both stored words, names the wanted source. Selecting the live port takes effect at once. Selecting a stored word waits for the next bus stop strobe.

Two pins override the mode field. `mux_sel` high routes the live port. `override_n` low also forces the live port, whatever the other controls hold.

Stored words do not reach the output as soon as they are written. Each write strobe starts a commit timer that models a slow non-volatile store. The new value becomes visible only when the timer expires, and only if that word is the current source. The bus protocol and the register file that produces the data and strobes sit outside this block.

Top module: `outsel_mux`

## Requirements
- R1: While `rst_n` is low and after its release, the selection is the live port, so `y` equals `port_i`. Both committed words reset to 0.
- R2: When `override_n` is 0, `y` equals `port_i` in the same cycle, regardless of `mux_sel`, `mode` and the stored selection.
- R3: When `override_n` is 1 and `mux_sel` is 1, `y` equals `port_i` whatever `mode` holds.
- R4: Mode `2'b10` drives `port_i` onto `y` in the same cycle. From the next clock edge it also makes the live port the stored selection.
- R5: Mode `2'b00` with `stop_evt` high at a clock edge makes word A the selection from that edge on. Without `stop_evt` the previous selection is kept.
- R6: Mode `2'b01` with `stop_evt` high at a clock edge makes word B the selection from that edge on. Without `stop_evt` the previous selection is kept.
- R7: Mode `2'b11` leaves the stored selection unchanged, even when `stop_evt` is high.
- R8: A write strobe (`wr_a` or `wr_b`) captures the data input at edge k. The committed word takes that value at edge k+COMMIT_CYCLES and keeps its old value before that. A committed word that is not selected has no effect on `y`.
- R9: A second write strobe to the same word before its commit completes replaces the pending data and restarts the timer. The earlier data is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Shared source mode field |
| wr_a | input | 1 | Write strobe for word A |
| wr_b | input | 1 | Write strobe for word B |
| reg_a | input | W | New data for word A |
| reg_b | input | W | New data for word B |
| stop_evt | input | 1 | One-cycle bus stop strobe |
| port_i | input | W | Live input port |
| mux_sel | input | 1 | External select, high routes the live port |
| override_n | input | 1 | Override, active low, forces the live port |
| y | output | W | Output port |

## Verification
The bench builds the block with W=6 and COMMIT_CYCLES=5. With a commit window that short, a rewrite in the middle of a pending commit, the last cycle before a commit and the commit edge itself can each be reached in a few clocks. A pseudo-random phase then mixes stop strobes, mode changes, overrides and writes that overlap pending commits across hundreds of cycles.

// File: rtl/outsel_mux.sv
module outsel_mux #(
  parameter int W = 6,
  parameter int COMMIT_CYCLES = 500000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  input  logic         stop_evt,
  input  logic [W-1:0] port_i,
  input  logic         mux_sel,
  input  logic         override_n,
  output logic [W-1:0] y
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CW-1:0] CLOAD = CW'(COMMIT_CYCLES);

  typedef enum logic [1:0] {SRC_I = 2'd0, SRC_A = 2'd1, SRC_B = 2'd2} src_t;

  src_t src;
  logic [1:0]   wr;
  logic [W-1:0] din  [2];
  logic [W-1:0] nv   [2];
  logic [W-1:0] pend [2];
  logic [CW-1:0] cnt [2];

  assign wr     = {wr_b, wr_a};
  assign din[0] = reg_a;
  assign din[1] = reg_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src <= SRC_I;
    else if (mode == 2'b10) src <= SRC_I;
    else if (stop_evt && mode == 2'b00) src <= SRC_A;
    else if (stop_evt && mode == 2'b01) src <= SRC_B;
  end

  for (genvar g = 0; g < 2; g++) begin : g_commit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[g]  <= '0;
        pend[g] <= '0;
        nv[g]   <= '0;
      end else if (wr[g]) begin
        cnt[g]  <= CLOAD;
        pend[g] <= din[g];
      end else if (cnt[g] != '0) begin
        cnt[g] <= cnt[g] - 1'b1;
        if (cnt[g] == CW'(1)) nv[g] <= pend[g];
      end
    end

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr[g] |=> cnt[g] == CLOAD);
    assert_no_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr[g] && cnt[g] != CW'(1)) |=> $stable(nv[g]));
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr[g] && cnt[g] != '0) |=> $stable(nv[g]));
  end

  wire live = !override_n || mux_sel || mode == 2'b10 || src == SRC_I;
  assign y = live ? port_i : (src == SRC_A ? nv[0] : nv[1]);

  assert_override_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !override_n |-> y == port_i);
  assert_muxsel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (override_n && mux_sel) |-> y == port_i);
  assert_live_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> src == SRC_I);
  assert_wait_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0 && !stop_evt) |=> $stable(src));
  assert_stop_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && stop_evt) |=> src == SRC_B);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> $stable(src));
endmodule

// File: tb/outsel_mux_test.sv
module outsel_mux_test;
  localparam int PERIOD = 10;
  localparam int W = 6;
  localparam int C = 5;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b00;
  logic wr_a = 0, wr_b = 0, stop_evt = 0, mux_sel = 0, override_n = 1;
  logic [W-1:0] reg_a = '0, reg_b = '0, port_i = 6'h15;
  logic [W-1:0] y;

  int total = 0, bad = 0;
  int m_src = 0;
  int m_nv[2], m_pend[2], m_cnt[2];

  always #(PERIOD/2) clk = ~clk;

  outsel_mux #(.W(W), .COMMIT_CYCLES(C)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_a(wr_a), .wr_b(wr_b),
    .reg_a(reg_a), .reg_b(reg_b), .stop_evt(stop_evt), .port_i(port_i),
    .mux_sel(mux_sel), .override_n(override_n), .y(y));

  initial begin
    for (int i = 0; i < 2; i++) begin m_nv[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0;
      for (int i = 0; i < 2; i++) begin m_nv[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; end
    end else begin
      if (mode == 2'b10) m_src = 0;
      else if (stop_evt && mode == 2'b00) m_src = 1;
      else if (stop_evt && mode == 2'b01) m_src = 2;
      for (int i = 0; i < 2; i++) begin
        if ((i == 0) ? wr_a : wr_b) begin
          m_pend[i] = (i == 0) ? int'(reg_a) : int'(reg_b);
          m_cnt[i] = C;
        end else if (m_cnt[i] > 0) begin
          if (m_cnt[i] == 1) m_nv[i] = m_pend[i];
          m_cnt[i]--;
        end
      end
    end
  end

  function automatic int model_y();
    if (!override_n || mux_sel || mode == 2'b10 || m_src == 0) return int'(port_i);
    return (m_src == 1) ? m_nv[0] : m_nv[1];
  endfunction

  function automatic string model_tag();
    if (!rst_n) return "R1";
    if (!override_n) return "R2";
    if (mux_sel) return "R3";
    if (mode == 2'b10) return "R4";
    if (m_src == 1) return "R5";
    if (m_src == 2) return "R6";
    return "R7";
  endfunction

  task automatic expect_y(string tag, int exp);
    total++;
    if (int'(y) != exp) begin
      bad++;
      $display("FAIL %s: y=%0h expected=%0h at %0t", tag, y, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    expect_y(model_tag(), model_y());
  endtask

  task automatic cycn(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: expired, expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    cycn(2);
    expect_y("R1", 'h15);
    rst_n = 1;
    cyc();
    expect_y("R1", 'h15);

    mode = 2'b00; reg_a = 6'h2A; wr_a = 1; cyc(); wr_a = 0;
    cycn(C + 1);
    expect_y("R5", 'h15);
    stop_evt = 1; cyc(); stop_evt = 0;
    expect_y("R5", 'h2A);

    reg_a = 6'h11; wr_a = 1; cyc(); wr_a = 0;
    cycn(C - 1);
    expect_y("R8", 'h2A);
    cyc();
    expect_y("R8", 'h11);

    reg_a = 6'h07; wr_a = 1; cyc(); wr_a = 0;
    cycn(1);
    reg_a = 6'h22; wr_a = 1; cyc(); wr_a = 0;
    cycn(C - 1);
    expect_y("R9", 'h11);
    cyc();
    expect_y("R9", 'h22);

    mode = 2'b01; reg_b = 6'h33; wr_b = 1; cyc(); wr_b = 0;
    cycn(C + 1);
    expect_y("R6", 'h22);
    stop_evt = 1; cyc(); stop_evt = 0;
    expect_y("R6", 'h33);

    reg_a = 6'h3C; wr_a = 1; cyc(); wr_a = 0;
    cycn(C + 1);
    expect_y("R8", 'h33);

    mode = 2'b11; stop_evt = 1; cyc(); stop_evt = 0;
    expect_y("R7", 'h33);

    port_i = 6'h05; mode = 2'b10; #1;
    expect_y("R4", 'h05);
    cyc();
    mode = 2'b11; stop_evt = 1; cyc(); stop_evt = 0;
    expect_y("R4", 'h05);

    mode = 2'b01; stop_evt = 1; cyc(); stop_evt = 0;
    expect_y("R6", 'h33);
    mux_sel = 1; port_i = 6'h29; #1;
    expect_y("R3", 'h29);
    mode = 2'b00; cyc();
    expect_y("R3", 'h29);
    mux_sel = 0; override_n = 0; port_i = 6'h1E; #1;
    expect_y("R2", 'h1E);
    cyc();
    override_n = 1; #1;
    expect_y("R2", 'h33);

    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mode = lfsr[1:0];
      stop_evt = lfsr[2] & lfsr[3];
      wr_a = lfsr[4] & lfsr[5] & lfsr[6];
      wr_b = lfsr[7] & lfsr[8] & lfsr[9];
      reg_a = lfsr[15:10];
      reg_b = lfsr[11:6];
      port_i = lfsr[5:0] ^ lfsr[15:10];
      mux_sel = (lfsr[12:10] == 3'b111);
      override_n = (lfsr[15:13] != 3'b000);
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule